// File: doc/BRIEF.md
# BCD Calendar Counter with 12/24-Hour Hours

This block keeps a wall-clock time and date in packed BCD: seconds, minutes, hours, day of week, day of month, month and a two-digit year standing for 2000 to 2099. An internal prescaler counts pulses on a tick input and advances the time by one second every `TICKS_PER_SEC` pulses. The carry runs through every field, so a month ends on the right day and a year-end rolls the year.

The hour byte holds its own format. With bit 6 clear it counts 00 to 23. With bit 6 set it counts 1 to 12 and bit 5 marks PM. Software writes any byte through a simple register port and reads any byte back by address. Writing a time byte restarts the prescaler. A halt bit in a control byte freezes the clock. The ports are plain control pins. They carry no stream and have no back-pressure: a write takes effect on the clock edge where `wr_en` is high, and `rd_data` follows `rd_addr` combinationally.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hour 0x00 (24-hour), weekday 0x01, date 0x01, month 0x01, year 0x00 and control 0x00.
- R2: Addresses: 0 seconds, 1 minutes, 2 hour, 3 weekday, 4 date, 5 month, 6 year, 7 control. A write stores `wr_data` unchanged, and the byte reads back on `rd_data` from the next cycle.
- R3: While running, the seconds advance once per `TICKS_PER_SEC` tick pulses. After reset, the first advance happens on the `TICKS_PER_SEC`-th pulse.
- R4: A write to any time address (0 to 6) restarts the prescaler, so the next advance comes a full `TICKS_PER_SEC` pulses later. A write to control does not restart it.
- R5: Seconds and minutes count 0x00 to 0x59. Each wraps to 0x00 and carries into the next field.
- R6: In 24-hour mode (hour bit 6 = 0) the hour counts 0x00 to 0x23. 0x23 wraps to 0x00 and carries into the day.
- R7: In 12-hour mode (bit 6 = 1, bit 5 = PM, bits 4:0 = hour 01 to 12 in BCD): 11 to 12 toggles PM; 12 to 01 keeps PM. Only 11 PM to 12 AM carries into the day, so 0x71 becomes 0x52.
- R8: The weekday counts 1 to 7 and wraps from 7 to 1 on a day carry.
- R9: On a day carry the date wraps to 0x01 once it is at or above the month's last day (31, or 30 for months 04, 06, 09 and 11). Otherwise it increments in BCD.
- R10: February ends at 0x29 when the binary year is divisible by 4 (year 00 included) and at 0x28 otherwise.
- R11: Month 0x12 wraps to 0x01 and carries into the year. Year 0x99 wraps to 0x00.
- R12: With control bit 7 set, tick pulses are ignored: no field advances and the prescaler holds its count. Register writes still take effect.
- R13: In a cycle with a time write, no field advances, even if the tick would complete a second. The write still lands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse from the time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Byte at `rd_addr` |

## Verification
The bench targets the carry boundaries:
- 23:59:59 into a new day. A wrong design would fail to wrap the hour or would skip the weekday.
- The 12-hour transitions 11 to 12 and 12 to 01. A design that toggled PM on the wrong edge, or carried the day at noon, would show a wrong hour byte or date.
- Month ends for 30-day months, for February in leap and common years (year 00 included), and for the year-end. A wrong length table gives dates of 0x31 in April or 0x29 in 2023.
- Prescaler timing after writes, after halting, and with a write in the same cycle as the completing tick. A design that did not restart the count would advance a second early.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NTIME = 7;
  localparam int AW    = 3;

  localparam logic [AW-1:0] A_SEC  = 3'd0;
  localparam logic [AW-1:0] A_MIN  = 3'd1;
  localparam logic [AW-1:0] A_HOUR = 3'd2;
  localparam logic [AW-1:0] A_WDAY = 3'd3;
  localparam logic [AW-1:0] A_DATE = 3'd4;
  localparam logic [AW-1:0] A_MON  = 3'd5;
  localparam logic [AW-1:0] A_YEAR = 3'd6;
  localparam logic [AW-1:0] A_CTRL = 3'd7;

  localparam int HALT_BIT = 7;
  localparam int H12_BIT  = 6;
  localparam int PM_BIT   = 5;

  // Packed so that index [0] is seconds and [6] is year.
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon,
                                          input logic [7:0] year);
    logic [6:0] yb;
    yb = bcd_to_bin(year);
    case (mon)
      8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic clr,
  output logic sec_stb
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= '0;
    else if (run && tick)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign sec_stb = run & tick & ~clr & (cnt == LAST);

  // R4: a restart leaves the count at zero
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R12: while stopped the count holds
  a_r12_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt));

  generate
    if (TICKS_PER_SEC > 1) begin : g_spacing
      // R3: two seconds never complete on back-to-back cycles
      a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        sec_stb |=> !sec_stb);
    end
  endgenerate
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
  import rtc_cal_pkg::*;
(
  input  logic [7:0] hour_in,
  output logic [7:0] hour_out,
  output logic       day_carry
);
  logic [7:0] hr;
  logic       pm;

  always_comb begin
    hour_out  = hour_in;
    day_carry = 1'b0;
    pm        = hour_in[PM_BIT];
    hr        = 8'h00;
    if (hour_in[H12_BIT]) begin
      hr = {3'b000, hour_in[4:0]};
      if (hr >= 8'h12) begin
        hr = 8'h01;                 // 12 -> 1, PM unchanged
      end else if (hr == 8'h11) begin
        hr        = 8'h12;
        day_carry = pm;             // 11 PM -> 12 AM starts a new day
        pm        = ~pm;
      end else begin
        hr = bcd_inc(hr);
      end
      hour_out = {1'b0, 1'b1, pm, hr[4:0]};
    end else begin
      hr = {2'b00, hour_in[5:0]};
      if (hr >= 8'h23) begin
        hour_out  = 8'h00;
        day_carry = 1'b1;
      end else begin
        hour_out = bcd_inc(hr);
      end
    end
  end
endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_cal_pkg::*;
(
  input  cal_t cur,
  output cal_t nxt
);
  logic [7:0] hour_adv;
  logic       hour_dc;
  logic       c_sec, c_min, c_day, c_mon, c_year;
  logic       date_end;

  rtc_hour_step u_hour (
    .hour_in  (cur.hour),
    .hour_out (hour_adv),
    .day_carry(hour_dc)
  );

  always_comb begin
    c_sec    = (cur.sec >= 8'h59);
    c_min    = c_sec && (cur.min >= 8'h59);
    c_day    = c_min && hour_dc;
    date_end = (cur.date >= last_day(cur.mon, cur.year));
    c_mon    = c_day && date_end;
    c_year   = c_mon && (cur.mon >= 8'h12);

    nxt.sec  = c_sec ? 8'h00 : bcd_inc(cur.sec);
    nxt.min  = c_sec ? ((cur.min >= 8'h59) ? 8'h00 : bcd_inc(cur.min)) : cur.min;
    nxt.hour = c_min ? hour_adv : cur.hour;
    nxt.wday = c_day ? ((cur.wday >= 8'h07) ? 8'h01 : cur.wday + 8'd1) : cur.wday;
    nxt.date = c_day ? (date_end ? 8'h01 : bcd_inc(cur.date)) : cur.date;
    nxt.mon  = c_mon ? ((cur.mon >= 8'h12) ? 8'h01 : bcd_inc(cur.mon)) : cur.mon;
    nxt.year = c_year ? ((cur.year >= 8'h99) ? 8'h00 : bcd_inc(cur.year)) : cur.year;
  end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam logic [NTIME-1:0][7:0] RST_VAL =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic [NTIME-1:0][7:0] tregs;
  logic [7:0]            ctrl_q;
  cal_t                  cur, nxt;
  logic                  wr_time, halt, sec_stb;

  assign wr_time = wr_en && (wr_addr != A_CTRL);
  assign halt    = ctrl_q[HALT_BIT];
  assign cur     = cal_t'(tregs);

  rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (~halt),
    .clr    (wr_time),
    .sec_stb(sec_stb)
  );

  rtc_cal_step u_step (
    .cur(cur),
    .nxt(nxt)
  );

  logic [NTIME-1:0][7:0] nxt_v;
  assign nxt_v = nxt;

  generate
    for (genvar i = 0; i < NTIME; i++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 tregs[i] <= RST_VAL[i];
        else if (wr_en && wr_addr == AW'(i))        tregs[i] <= wr_data;
        else if (sec_stb)                           tregs[i] <= nxt_v[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           ctrl_q <= 8'h00;
    else if (wr_en && wr_addr == A_CTRL)  ctrl_q <= wr_data;
  end

  assign rd_data = (rd_addr == A_CTRL) ? ctrl_q : tregs[rd_addr];

  // R2: a written hour byte is stored verbatim
  a_r2_load_hour: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_HOUR) |=> (tregs[A_HOUR] == $past(wr_data)));

  // R12: halted and not written means frozen
  a_r12_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_time) |=> $stable(tregs));

  // R13: a write to another field leaves the seconds alone
  a_r13_write_blocks_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_time && wr_addr != A_SEC) |=> $stable(tregs[A_SEC]));

  // R7: noon rolls to one PM
  a_r7_noon_to_one: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_stb && tregs[A_SEC] == 8'h59 && tregs[A_MIN] == 8'h59 &&
     tregs[A_HOUR] == 8'h72) |=> (tregs[A_HOUR] == 8'h61));

  // R6: 23:59:59 rolls to 00:00:00
  a_r6_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_stb && tregs[A_SEC] == 8'h59 && tregs[A_MIN] == 8'h59 &&
     tregs[A_HOUR] == 8'h23) |=> (tregs[A_HOUR] == 8'h00 && tregs[A_SEC] == 8'h00));
endmodule

// File: tb/tb_rtc_bcd_calendar.sv
`timescale 1ns/1ps
module tb_rtc_bcd_calendar;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit mon_busy = 1'b0;

  logic [2:0] q_addr[$];
  logic [7:0] q_exp[$];
  string      q_req[$];

  always #4 clk = ~clk;

  rtc_bcd_calendar #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Monitor: pops expected items and compares them with the read port.
  initial begin
    forever begin
      wait (q_addr.size() != 0);
      mon_busy = 1'b1;
      begin
        logic [2:0] a;
        logic [7:0] e;
        string r;
        a = q_addr.pop_front();
        e = q_exp.pop_front();
        r = q_req.pop_front();
        rd_addr = a;
        #0.2;
        checks++;
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s addr=%0d actual=%02h expected=%02h", r, a, rd_data, e);
        end
      end
      mon_busy = 1'b0;
      #0.05;
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string r);
    q_addr.push_back(a);
    q_exp.push_back(e);
    q_req.push_back(r);
    wait (q_addr.size() == 0 && !mon_busy);
    #0.01;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, m, h, wd, d, mo, y);
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, wd);
    wr(3'd4, d); wr(3'd5, mo); wr(3'd6, y);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_reg(0, 8'h00, "R1"); expect_reg(1, 8'h00, "R1");
    expect_reg(2, 8'h00, "R1"); expect_reg(3, 8'h01, "R1");
    expect_reg(4, 8'h01, "R1"); expect_reg(5, 8'h01, "R1");
    expect_reg(6, 8'h00, "R1"); expect_reg(7, 8'h00, "R1");

    // R3 prescaler
    ticks(TPS - 1); expect_reg(0, 8'h00, "R3");
    ticks(1);       expect_reg(0, 8'h01, "R3");

    // R4 time write restarts prescaler, control write does not
    ticks(2); wr(3'd1, 8'h05);
    ticks(TPS - 1); expect_reg(0, 8'h01, "R4");
    ticks(1);       expect_reg(0, 8'h02, "R4");
    expect_reg(1, 8'h05, "R2");
    ticks(2); wr(3'd7, 8'h00); ticks(TPS - 2);
    expect_reg(0, 8'h03, "R4");

    // R5 minute and second rollover
    set_time(8'h59, 8'h59, 8'h22, 8'h02, 8'h10, 8'h03, 8'h21);
    ticks(TPS);
    expect_reg(0, 8'h00, "R5"); expect_reg(1, 8'h00, "R5");
    expect_reg(2, 8'h23, "R5"); expect_reg(4, 8'h10, "R5");

    // R6 / R8 midnight and weekday wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h06, 8'h24);
    ticks(TPS);
    expect_reg(2, 8'h00, "R6"); expect_reg(3, 8'h01, "R8");
    expect_reg(4, 8'h16, "R6");

    // R7 12-hour transitions
    set_time(8'h59, 8'h59, 8'h51, 8'h03, 8'h15, 8'h06, 8'h24);
    ticks(TPS);
    expect_reg(2, 8'h72, "R7"); expect_reg(4, 8'h15, "R7");
    set_time(8'h59, 8'h59, 8'h72, 8'h03, 8'h15, 8'h06, 8'h24);
    ticks(TPS);
    expect_reg(2, 8'h61, "R7");
    set_time(8'h59, 8'h59, 8'h71, 8'h03, 8'h15, 8'h06, 8'h24);
    ticks(TPS);
    expect_reg(2, 8'h52, "R7"); expect_reg(4, 8'h16, "R7");
    expect_reg(3, 8'h04, "R8");

    // R9 month lengths
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h24);
    ticks(TPS);
    expect_reg(4, 8'h01, "R9"); expect_reg(5, 8'h05, "R9");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h05, 8'h24);
    ticks(TPS);
    expect_reg(4, 8'h31, "R9");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h04, 8'h24);
    ticks(TPS);
    expect_reg(4, 8'h01, "R9"); expect_reg(5, 8'h05, "R9");

    // R10 February
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    ticks(TPS);
    expect_reg(4, 8'h01, "R10"); expect_reg(5, 8'h03, "R10");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    ticks(TPS);
    expect_reg(4, 8'h29, "R10");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    ticks(TPS);
    expect_reg(4, 8'h29, "R10");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    ticks(TPS);
    expect_reg(4, 8'h01, "R10"); expect_reg(5, 8'h03, "R10");

    // R11 year end
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
    ticks(TPS);
    expect_reg(4, 8'h01, "R11"); expect_reg(5, 8'h01, "R11");
    expect_reg(6, 8'h00, "R11");

    // R12 halt
    wr(3'd7, 8'h80);
    expect_reg(7, 8'h80, "R2");
    ticks(2 * TPS);
    expect_reg(0, 8'h00, "R12");
    wr(3'd0, 8'h10);
    expect_reg(0, 8'h10, "R12");
    ticks(1);
    wr(3'd7, 8'h00);
    ticks(TPS - 1); expect_reg(0, 8'h10, "R12");
    ticks(1);       expect_reg(0, 8'h11, "R12");

    // R13 write coinciding with the completing tick
    ticks(TPS - 1);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h42;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    expect_reg(0, 8'h11, "R13"); expect_reg(1, 8'h42, "R13");
    ticks(TPS - 1); expect_reg(0, 8'h11, "R13");
    ticks(1);       expect_reg(0, 8'h12, "R13");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule